// File: doc/BRIEF.md
# Buck-Boost Operating Mode Selector and Switch Gate Controller

This block decides whether a four-switch DC-DC stage runs as a step-down (buck), step-up (boost) or combined (buck-boost) converter. It gets four comparator flags that compare the input voltage against a regulated output target of 5 V. It also gets a one-cycle strobe that marks the start of each PWM period. Each of the two mode boundaries has an upper and a lower threshold. A mode is left only when the input crosses the far threshold. A new mode is adopted only at a period start, and only after the same new mode has been requested at that many consecutive period starts.

The selected mode routes four PWM phase inputs onto the four power-switch gates. M1 and M2 form the input leg: M1 is the high side and M2 connects to ground. M3 and M4 form the output leg: M3 connects to ground and M4 is the high side. Depending on the mode, each switch either follows its phase input or is held at a fixed level. The gate outputs are registered and interlocked. The two switches of a leg are never on together, and a switch turns on only after its partner has been off for a full clock cycle. Gates stay off from reset until the first period start has been seen.

Top module: `bb_mode_sel`

## Requirements
- R1: After reset the mode output reads buck-boost (`mode_o` = 2'b11). Every gate stays off until the clock edge after the first sampled period start.
- R2: Mode codes are buck = 2'b01, boost = 2'b10 and buck-boost = 2'b11. From buck-boost, a set buck-high flag requests buck and a clear boost-low flag requests boost. From boost or buck, a set buck-high flag requests buck and a clear boost-low flag requests boost, so the block can jump directly between buck and boost.
- R3: Hysteresis. Buck is kept while the buck-low flag is set, even with the buck-high flag clear, and is left for buck-boost when buck-low clears. Boost is kept while boost-high is clear and is left for buck-boost when boost-high sets.
- R4: `mode_o` changes only on a clock edge at which `period_start_i` is high.
- R5: A requested mode is adopted at the STABLE_PERIODS-th consecutive period start that requests it. A period start that requests the current mode or a different mode restarts the count.
- R6: In buck mode, M3 (`gate_o[2]`) is held off and M4 (`gate_o[3]`) on, while M1 (`gate_o[0]`) follows phase A and M2 (`gate_o[1]`) follows phase B.
- R7: In boost mode, M1 is held on and M2 off, while M3 follows phase C and M4 follows phase D.
- R8: In buck-boost mode, all four switches toggle: phases A and C drive M1 and M3 together, and phases B and D drive M2 and M4 together.
- R9: Within a leg, the two gates are never on together. A gate turns on only if its partner was off on the previous cycle, so a handover always leaves one cycle with both gates off.
- R10: If both phases that drive one leg request on, the ground-side switch (M2 or M3) wins and the high side is turned off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vin_boost_lo_i | input | 1 | Input voltage above the lower boost-boundary threshold |
| vin_boost_hi_i | input | 1 | Input voltage above the upper boost-boundary threshold |
| vin_buck_lo_i | input | 1 | Input voltage above the lower buck-boundary threshold |
| vin_buck_hi_i | input | 1 | Input voltage above the upper buck-boundary threshold |
| period_start_i | input | 1 | One-cycle strobe at the start of each PWM period |
| ph_a_i | input | 1 | PWM phase A (input leg, high side) |
| ph_b_i | input | 1 | PWM phase B (input leg, ground side) |
| ph_c_i | input | 1 | PWM phase C (output leg, ground side) |
| ph_d_i | input | 1 | PWM phase D (output leg, high side) |
| mode_o | output | 2 | Current mode code |
| gate_o | output | 4 | Gate drives: bit 0 M1, bit 1 M2, bit 2 M3, bit 3 M4 |

## Verification
Several properties are checked by assertions on every cycle. These are the leg interlock with its one-cycle off gap, the rule that the mode moves only on a period start, the legality of the mode code, the switches held off in buck and boost, and the gates staying dark before the first period start. Other behaviour shows only in the bench's scenarios. This covers the hysteresis bands, the count of consecutive identical requests and its restart on an interrupted request, the direct jumps between boost and buck, and the phase routing in each mode. The bench checks these with a reference model compared every cycle and with targeted probes.

// File: rtl/bb_mode_sel_pkg.sv
package bb_mode_sel_pkg;

    typedef enum logic [1:0] {
        MODE_BUCK  = 2'b01,
        MODE_BOOST = 2'b10,
        MODE_BB    = 2'b11
    } mode_e;

    localparam int NUM_THR   = 4;
    localparam int THR_K_LO  = 0;
    localparam int THR_K_HI  = 1;
    localparam int THR_B_LO  = 2;
    localparam int THR_B_HI  = 3;

    localparam int NUM_GATES = 4;
    localparam int G_M1      = 0;
    localparam int G_M2      = 1;
    localparam int G_M3      = 2;
    localparam int G_M4      = 3;

endpackage

// File: rtl/bb_mode_decide.sv
module bb_mode_decide
    import bb_mode_sel_pkg::*;
(
    input  mode_e                cur_i,
    input  logic [NUM_THR-1:0]   thr_i,
    output mode_e                cand_o
);

    always_comb begin
        cand_o = cur_i;
        case (cur_i)
            MODE_BB: begin
                if (thr_i[THR_B_HI])       cand_o = MODE_BUCK;
                else if (!thr_i[THR_K_LO]) cand_o = MODE_BOOST;
            end
            MODE_BUCK: begin
                if (!thr_i[THR_K_LO])      cand_o = MODE_BOOST;
                else if (!thr_i[THR_B_LO]) cand_o = MODE_BB;
            end
            MODE_BOOST: begin
                if (thr_i[THR_B_HI])       cand_o = MODE_BUCK;
                else if (thr_i[THR_K_HI])  cand_o = MODE_BB;
            end
            default: cand_o = MODE_BB;
        endcase
    end

endmodule

// File: rtl/bb_mode_filter.sv
module bb_mode_filter
    import bb_mode_sel_pkg::*;
#(
    parameter int STABLE_PERIODS = 3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  period_start_i,
    input  mode_e cand_i,
    output mode_e mode_o,
    output logic  valid_o
);

    localparam int CW = $clog2(STABLE_PERIODS + 1);

    typedef struct packed {
        mode_e          mode;
        mode_e          pend;
        logic [CW-1:0]  cnt;
        logic           valid;
    } filt_t;

    filt_t st_d, st_q;
    logic [CW-1:0] run;

    always_comb begin
        st_d = st_q;
        run  = (cand_i == st_q.pend) ? st_q.cnt + CW'(1) : CW'(1);
        if (period_start_i) begin
            st_d.valid = 1'b1;
            if (cand_i == st_q.mode) begin
                st_d.pend = st_q.mode;
                st_d.cnt  = '0;
            end else if (run == CW'(STABLE_PERIODS)) begin
                st_d.mode = cand_i;
                st_d.pend = cand_i;
                st_d.cnt  = '0;
            end else begin
                st_d.pend = cand_i;
                st_d.cnt  = run;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode  <= MODE_BB;
            st_q.pend  <= MODE_BB;
            st_q.cnt   <= '0;
            st_q.valid <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o  = st_q.mode;
    assign valid_o = st_q.valid;

endmodule

// File: rtl/bb_gate_map.sv
module bb_gate_map
    import bb_mode_sel_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  mode_e                mode_i,
    input  logic                 valid_i,
    input  logic [3:0]           ph_i,
    output logic [NUM_GATES-1:0] gate_o
);

    localparam int NUM_LEGS = NUM_GATES / 2;

    typedef struct packed {
        logic [NUM_GATES-1:0] gate;
    } gate_st_t;

    gate_st_t st_d, st_q;
    logic [NUM_GATES-1:0] raw;
    logic [NUM_GATES-1:0] nxt;

    // phase index equals gate index: A->M1, B->M2, C->M3, D->M4
    always_comb begin
        case (mode_i)
            MODE_BUCK:  raw = {1'b1, 1'b0, ph_i[G_M2], ph_i[G_M1]};
            MODE_BOOST: raw = {ph_i[G_M4], ph_i[G_M3], 1'b0, 1'b1};
            default:    raw = ph_i;
        endcase
    end

    for (genvar l = 0; l < NUM_LEGS; l++) begin : g_leg
        localparam int HI = (l == 0) ? G_M1 : G_M4;
        localparam int LO = (l == 0) ? G_M2 : G_M3;
        assign nxt[HI] = valid_i & raw[HI] & ~raw[LO] & ~st_q.gate[LO];
        assign nxt[LO] = valid_i & raw[LO] & ~st_q.gate[HI];
    end

    always_comb begin
        st_d      = st_q;
        st_d.gate = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gate_o = st_q.gate;

endmodule

// File: rtl/bb_mode_sel.sv
module bb_mode_sel
    import bb_mode_sel_pkg::*;
#(
    parameter int STABLE_PERIODS = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vin_boost_lo_i,
    input  logic       vin_boost_hi_i,
    input  logic       vin_buck_lo_i,
    input  logic       vin_buck_hi_i,
    input  logic       period_start_i,
    input  logic       ph_a_i,
    input  logic       ph_b_i,
    input  logic       ph_c_i,
    input  logic       ph_d_i,
    output logic [1:0] mode_o,
    output logic [3:0] gate_o
);

    logic [NUM_THR-1:0] thr;
    mode_e              cur_mode;
    mode_e              cand_mode;
    logic               gates_valid;

    assign thr = {vin_buck_hi_i, vin_buck_lo_i, vin_boost_hi_i, vin_boost_lo_i};

    bb_mode_decide u_decide (
        .cur_i  (cur_mode),
        .thr_i  (thr),
        .cand_o (cand_mode)
    );

    bb_mode_filter #(.STABLE_PERIODS(STABLE_PERIODS)) u_filter (
        .clk            (clk),
        .rst_n          (rst_n),
        .period_start_i (period_start_i),
        .cand_i         (cand_mode),
        .mode_o         (cur_mode),
        .valid_o        (gates_valid)
    );

    bb_gate_map u_gates (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (cur_mode),
        .valid_i (gates_valid),
        .ph_i    ({ph_d_i, ph_c_i, ph_b_i, ph_a_i}),
        .gate_o  (gate_o)
    );

    assign mode_o = cur_mode;

endmodule

// File: rtl/bb_mode_sel_chk.sv
module bb_mode_sel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       period_start_i,
    input logic [1:0] mode_o,
    input logic [3:0] gate_o
);

    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= seen_q | period_start_i;
    end

    // R1
    dark_before_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |=> (gate_o == 4'b0000));

    // R2
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'b00);

    // R4
    mode_on_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !period_start_i |=> $stable(mode_o));

    // R6
    buck_m3_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b01) |=> !gate_o[2]);

    // R7
    boost_m2_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b10) |=> !gate_o[1]);

    // R9
    in_leg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_o[0] && gate_o[1]));

    // R9
    out_leg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_o[2] && gate_o[3]));

    // R9
    m2_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_o[1]) |-> $past(!gate_o[0]));

    // R9
    m3_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_o[2]) |-> $past(!gate_o[3]));

endmodule

bind bb_mode_sel bb_mode_sel_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .period_start_i (period_start_i),
    .mode_o         (mode_o),
    .gate_o         (gate_o)
);

// File: tb/bb_mode_sel_tb_top.sv
module bb_mode_sel_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NSTAB      = 3;
    localparam int PLEN       = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic k_lo = 0, k_hi = 0, b_lo = 0, b_hi = 0;
    logic sync = 0;
    logic pa = 0, pb = 0, pc = 0, pd = 0;
    logic [1:0] mode_o;
    logic [3:0] gate_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bb_mode_sel #(.STABLE_PERIODS(NSTAB)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .vin_boost_lo_i(k_lo), .vin_boost_hi_i(k_hi),
        .vin_buck_lo_i(b_lo), .vin_buck_hi_i(b_hi),
        .period_start_i(sync),
        .ph_a_i(pa), .ph_b_i(pb), .ph_c_i(pc), .ph_d_i(pd),
        .mode_o(mode_o), .gate_o(gate_o)
    );

    // reference model
    int m_mode, m_pend, m_cnt;
    bit m_valid;
    bit [3:0] m_gate;

    function automatic int want_mode(int cur);
        if (b_hi) return 1;
        if (!k_lo) return 2;
        if (cur == 1 && !b_lo) return 3;
        if (cur == 2 && k_hi) return 3;
        return cur;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 3; m_pend = 3; m_cnt = 0; m_valid = 0; m_gate = 0;
        end else begin
            bit [3:0] want;
            bit [3:0] g;
            int c;
            if (m_mode == 1)      want = {1'b1, 1'b0, pb, pa};
            else if (m_mode == 2) want = {pd, pc, 1'b0, 1'b1};
            else                  want = {pd, pc, pb, pa};
            g = 0;
            if (m_valid) begin
                g[1] = want[1] && !m_gate[0];
                g[0] = want[0] && !want[1] && !m_gate[1];
                g[2] = want[2] && !m_gate[3];
                g[3] = want[3] && !want[2] && !m_gate[2];
            end
            m_gate = g;
            if (sync) begin
                m_valid = 1;
                c = want_mode(m_mode);
                if (c == m_mode) begin
                    m_pend = m_mode; m_cnt = 0;
                end else begin
                    m_cnt = (c == m_pend) ? m_cnt + 1 : 1;
                    m_pend = c;
                    if (m_cnt >= NSTAB) begin
                        m_mode = c; m_cnt = 0;
                    end
                end
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R5 mode vs model", int'(mode_o), m_mode);
            if (m_mode == 1)      chk("R6 gates vs model", int'(gate_o), int'(m_gate));
            else if (m_mode == 2) chk("R7 gates vs model", int'(gate_o), int'(m_gate));
            else                  chk("R8 gates vs model", int'(gate_o), int'(m_gate));
        end
    end

    // pat 0: A,C in first half, B,D in second half; pat 1: A,B overlap then C,D
    task automatic run_periods(input logic [3:0] thr, input int pat, input int n, input bit probe);
        for (int p = 0; p < n; p++) begin
            for (int k = 0; k < PLEN; k++) begin
                {b_hi, b_lo, k_hi, k_lo} = thr;
                sync = (k == 0);
                if (pat == 0) begin
                    pa = (k < 4); pc = (k < 4); pb = (k >= 4); pd = (k >= 4);
                end else begin
                    pa = (k < 4); pb = (k < 4); pc = (k >= 4); pd = (k >= 4);
                end
                @(negedge clk);
                if (probe && pat == 0 && k == 4) chk("R9 input leg gap", int'(gate_o[1:0]), 0);
                if (probe && pat == 0 && k == 5) chk("R9 ground side on after gap", int'(gate_o[1:0]), 2);
                if (probe && pat == 1 && k == 3) chk("R10 ground side wins", int'(gate_o[1:0]), 2);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset mode", int'(mode_o), 3);
        chk("R1 reset gates", int'(gate_o), 0);
        rst_n = 1'b1;
        for (int k = 0; k < 5; k++) begin
            {b_hi, b_lo, k_hi, k_lo} = 4'b0111;
            pa = k[0]; pb = ~k[0]; pc = k[0]; pd = ~k[0];
            @(negedge clk);
            chk("R1 gates dark before first period", int'(gate_o), 0);
        end
        run_periods(4'b0111, 0, 2, 1'b0);
        chk("R2 mid band keeps buck-boost", int'(mode_o), 3);
        run_periods(4'b1111, 0, 2, 1'b0);
        chk("R5 two requests not enough", int'(mode_o), 3);
        run_periods(4'b1111, 0, 1, 1'b0);
        chk("R2 high input selects buck", int'(mode_o), 1);
        run_periods(4'b0111, 0, 4, 1'b0);
        chk("R3 buck held inside band", int'(mode_o), 1);
        run_periods(4'b0011, 0, 3, 1'b0);
        chk("R3 buck left below lower threshold", int'(mode_o), 3);
        run_periods(4'b0011, 0, 1, 1'b1);
        run_periods(4'b0000, 0, 2, 1'b0);
        run_periods(4'b0011, 0, 1, 1'b0);
        run_periods(4'b0000, 0, 2, 1'b0);
        chk("R5 interrupted request restarts count", int'(mode_o), 3);
        run_periods(4'b0000, 0, 1, 1'b0);
        chk("R2 low input selects boost", int'(mode_o), 2);
        run_periods(4'b0001, 0, 4, 1'b0);
        chk("R3 boost held inside band", int'(mode_o), 2);
        run_periods(4'b1111, 0, 3, 1'b0);
        chk("R2 boost jumps to buck", int'(mode_o), 1);
        run_periods(4'b0000, 1, 3, 1'b0);
        chk("R2 buck jumps to boost", int'(mode_o), 2);
        run_periods(4'b0011, 0, 3, 1'b0);
        chk("R3 boost left above upper threshold", int'(mode_o), 3);
        run_periods(4'b0011, 1, 2, 1'b1);
        run_periods(4'b0011, 0, 1, 1'b0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog act=1 exp=0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule